// File: doc/BRIEF.md
# Auto-Incrementing Pointer Data Port

This peripheral sits next to an 8-bit microcontroller core. It gives software two 16-bit address pointers. Each pointer has its own data-port address in external data space. When the CPU reads or writes one of these port addresses on its external-data bus, the block turns the access into a memory cycle at the address held in that channel's pointer. A read returns the memory byte in the same cycle. If the channel's increment bit is set, the pointer then steps forward by one.

Software loads the pointer bytes and a small control register through special-function-register (SFR) writes, and it can read each of them back. A block copy then needs no pointer arithmetic in the loop. Software reads the channel 1 port and writes the channel 2 port, over and over, and the bytes arrive in order at the destination.

All memory-side signals are combinational from the CPU request. The only state is the two pointers and the control register. The memory array and the CPU are outside the block.

Top module: `autoptr_port`

## Requirements
- R1: Each pointer is loaded and read back a byte at a time through SFR space. Channel 1 uses high byte 0x9A and low byte 0x9B. Channel 2 uses high byte 0x9C and low byte 0x9D.
- R2: The control register is at SFR 0xAF. Bit 0 is the global enable, bit 1 sets increment for channel 1, and bit 2 sets increment for channel 2. On readback, bits 7..3 are zero.
- R3: With the block enabled, a read of external-data address 0xE67B (channel 1) or 0xE67C (channel 2) returns, in the same cycle, the memory byte at that channel's pointer.
- R4: With the block enabled, a write to a channel's port address stores the byte in memory at that channel's pointer.
- R5: After a port access with the channel's increment bit set, the pointer is one higher from the next cycle on. Back-to-back accesses therefore use consecutive addresses.
- R6: If the channel's increment bit is clear, a port access leaves the pointer unchanged.
- R7: The increment carries from the low byte into the high byte, and 0xFFFF wraps to 0x0000.
- R8: With the global enable clear, port accesses make no memory cycle, leave both pointers unchanged, and reads return 0x00.
- R9: An external-data access to any address other than the two ports does not assert the port hit, makes no memory cycle and changes no pointer.
- R10: If an SFR write to a pointer byte lands in the same cycle as that pointer's increment, the written byte takes the CPU value. The other byte keeps its value from before the access, and no increment occurs.
- R11: Reset clears both pointers and the control register.
- R12: With both increments on, alternating reads of port 1 and writes of port 2 copy a block in order. With only channel 1 incrementing, every write lands on the same destination byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR readback of the addressed register, 0 if not owned |
| xd_req | input | 1 | External-data bus cycle valid |
| xd_we | input | 1 | External-data cycle is a write |
| xd_addr | input | 16 | External-data address |
| xd_wdata | input | 8 | External-data write byte |
| xd_rdata | output | 8 | Read data for a port access |
| xd_hit | output | 1 | Access targets one of the two port addresses |
| mem_en | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 16 | Memory address, taken from the selected pointer |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, combinational |

## Verification
The embedded assertions are checked on every cycle. They cover the pointer step and hold rules, the wrap to zero, and the rule that a CPU write beats an increment. They also check that a disabled or non-port access never produces a memory cycle, that a disabled read returns zero, that at most one channel is active at once, and that read data tracks memory. Some properties need memory contents or an ordering of many accesses, and only the bench's scenarios can show them. These are end-to-end block copies in both increment modes, consecutive addressing across back-to-back reads, carry from the low byte into the high byte, control-register readback masking, and memory that a disabled write leaves untouched.

// File: rtl/autoptr_pkg.sv
// Shared sizes and types for the auto-incrementing pointer port.
// Assumes a byte-wide data bus and pointers exactly two bytes wide.
package autoptr_pkg;
    localparam int NCH = 2;   // number of pointer channels
    localparam int AW  = 16;  // pointer / memory address width
    localparam int DW  = 8;   // data and SFR width

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] byte_t;

    // Packed so that en is bit 0 and inc[c] is bit c+1.
    typedef struct packed {
        logic [NCH-1:0] inc;
        logic           en;
    } ctrl_t;
endpackage

// File: rtl/autoptr_ctrl.sv
// Control register: global enable plus one increment bit per channel.
// Assumes the caller has already decoded the SFR address into wr.
module autoptr_ctrl
    import autoptr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr,
    input  byte_t wdata,
    output ctrl_t ctrl
);
    localparam int CW = $bits(ctrl_t);

    // Holds the control bits; loads on a decoded SFR write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr)
            ctrl <= ctrl_t'(wdata[CW-1:0]);
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(ctrl)); // R2
endmodule

// File: rtl/autoptr_chan.sv
// One pointer channel: a 16-bit address split into two SFR-writable bytes.
// A CPU byte write beats a same-cycle increment, and that increment is
// dropped. Assumes AW == 2*DW.
module autoptr_chan #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    logic          cpu_wr;
    logic [AW-1:0] ptr_inc;

    // Byte-write detect and the wrapping successor address.
    always_comb begin
        cpu_wr  = wr_lo | wr_hi;
        ptr_inc = ptr + AW'(1);
    end

    // Pointer register: CPU byte writes first, then increment, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (cpu_wr) begin
            if (wr_lo) ptr[DW-1:0]  <= wdata;
            if (wr_hi) ptr[AW-1:DW] <= wdata;
        end else if (step) begin
            ptr <= ptr_inc;
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step && !wr_lo && !wr_hi |=> ptr == AW'($past(ptr) + AW'(1))); // R5
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step && !wr_lo && !wr_hi |=> $stable(ptr)); // R6
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        step && !wr_lo && !wr_hi && (ptr == '1) |=> ptr == '0); // R7
    AST_CPU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        step && wr_lo && !wr_hi |=> ptr == {$past(ptr[AW-1:DW]), $past(wdata)}); // R10
endmodule

// File: rtl/autoptr_xbus.sv
// External-data side: decodes the per-channel port addresses, gates them
// with the global enable and steers the selected pointer onto the memory
// bus. Purely combinational; clk/rst_n only time the assertions.
module autoptr_xbus #(
    parameter int          NCH       = 2,
    parameter int          AW        = 16,
    parameter int          DW        = 8,
    parameter logic [15:0] PORT_BASE = 16'hE67B
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   xd_req,
    input  logic                   xd_we,
    input  logic [AW-1:0]          xd_addr,
    input  logic [DW-1:0]          xd_wdata,
    input  logic                   en,
    input  logic [NCH-1:0][AW-1:0] ptrs,
    input  logic [DW-1:0]          mem_rdata,
    output logic                   xd_hit,
    output logic [DW-1:0]          xd_rdata,
    output logic                   mem_en,
    output logic                   mem_we,
    output logic [AW-1:0]          mem_addr,
    output logic [DW-1:0]          mem_wdata,
    output logic [NCH-1:0]         acc
);
    logic [NCH-1:0] sel;

    for (genvar c = 0; c < NCH; c++) begin : g_dec
        // Port address match for channel c.
        always_comb sel[c] = xd_req && (xd_addr == AW'(PORT_BASE + c));
    end

    // Enable gating, pointer steering and read-data return.
    always_comb begin
        xd_hit    = |sel;
        acc       = en ? sel : '0;
        mem_en    = |acc;
        mem_we    = mem_en & xd_we;
        mem_wdata = xd_wdata;
        mem_addr  = '0;
        for (int c = 0; c < NCH; c++)
            if (acc[c]) mem_addr = ptrs[c];
        xd_rdata  = (mem_en && !xd_we) ? mem_rdata : '0;
    end

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc)); // R3
    AST_OFF_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !mem_en); // R8
    AST_OFF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        xd_req && !xd_we && !en |-> xd_rdata == '0); // R8
    AST_MISS_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        !xd_hit |-> !mem_en && acc == '0); // R9
endmodule

// File: rtl/autoptr_port.sv
// Top of the auto-incrementing pointer data port. Decodes SFR writes and
// reads for the control register and the pointer bytes, instantiates one
// pointer channel per NCH, and joins them to the external-data decoder.
// Assumes single-cycle combinational memory reads and AW == 2*DW.
module autoptr_port
    import autoptr_pkg::*;
#(
    parameter logic [7:0]  CTRL_SFR     = 8'hAF,
    parameter logic [7:0]  PTR_SFR_BASE = 8'h9A,
    parameter logic [15:0] PORT_BASE    = 16'hE67B
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sfr_wr,
    input  logic [7:0]    sfr_addr,
    input  logic [7:0]    sfr_wdata,
    output logic [7:0]    sfr_rdata,
    input  logic          xd_req,
    input  logic          xd_we,
    input  logic [15:0]   xd_addr,
    input  logic [7:0]    xd_wdata,
    output logic [7:0]    xd_rdata,
    output logic          xd_hit,
    output logic          mem_en,
    output logic          mem_we,
    output logic [15:0]   mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata
);
    localparam int CW = $bits(ctrl_t);

    ctrl_t                  ctrl;
    logic                   ctrl_wr;
    logic [NCH-1:0]         wr_lo, wr_hi, acc, step;
    logic [NCH-1:0][AW-1:0] ptrs;

    // Control register write decode.
    always_comb ctrl_wr = sfr_wr && (sfr_addr == CTRL_SFR);

    autoptr_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctrl_wr),
        .wdata (sfr_wdata),
        .ctrl  (ctrl)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Byte-write decode and increment qualifier for channel c.
        always_comb begin
            wr_hi[c] = sfr_wr && (sfr_addr == 8'(PTR_SFR_BASE + 2*c));
            wr_lo[c] = sfr_wr && (sfr_addr == 8'(PTR_SFR_BASE + 2*c + 1));
            step[c]  = acc[c] && ctrl.inc[c];
        end

        autoptr_chan #(.AW(AW), .DW(DW)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_lo (wr_lo[c]),
            .wr_hi (wr_hi[c]),
            .wdata (sfr_wdata),
            .step  (step[c]),
            .ptr   (ptrs[c])
        );
    end

    autoptr_xbus #(.NCH(NCH), .AW(AW), .DW(DW), .PORT_BASE(PORT_BASE)) u_xbus (
        .clk       (clk),
        .rst_n     (rst_n),
        .xd_req    (xd_req),
        .xd_we     (xd_we),
        .xd_addr   (xd_addr),
        .xd_wdata  (xd_wdata),
        .en        (ctrl.en),
        .ptrs      (ptrs),
        .mem_rdata (mem_rdata),
        .xd_hit    (xd_hit),
        .xd_rdata  (xd_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .acc       (acc)
    );

    // SFR readback of the addressed register; unowned addresses read zero.
    always_comb begin
        sfr_rdata = '0;
        if (sfr_addr == CTRL_SFR)
            sfr_rdata = DW'(ctrl);
        for (int c = 0; c < NCH; c++) begin
            if (sfr_addr == 8'(PTR_SFR_BASE + 2*c))     sfr_rdata = ptrs[c][AW-1:DW];
            if (sfr_addr == 8'(PTR_SFR_BASE + 2*c + 1)) sfr_rdata = ptrs[c][DW-1:0];
        end
    end

    AST_READ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && !mem_we |-> xd_rdata == mem_rdata); // R3
    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_addr == CTRL_SFR |-> sfr_rdata[DW-1:CW] == '0); // R2
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> ptrs == '0 && ctrl == '0); // R11
endmodule

// File: tb/sim_autoptr_port.sv
module sim_autoptr_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0]  A_CTRL = 8'hAF;
    localparam logic [7:0]  A_P1H = 8'h9A, A_P1L = 8'h9B;
    localparam logic [7:0]  A_P2H = 8'h9C, A_P2L = 8'h9D;
    localparam logic [15:0] PORT1 = 16'hE67B, PORT2 = 16'hE67C;

    logic        clk = 0, rst_n = 0;
    logic        sfr_wr = 0;
    logic [7:0]  sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
    logic        xd_req = 0, xd_we = 0;
    logic [15:0] xd_addr = 0;
    logic [7:0]  xd_wdata = 0, xd_rdata;
    logic        xd_hit, mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [7:0]  mem [0:1023];
    int          n_checks = 0, n_fail = 0, n_memwr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    autoptr_port u0 (.*);

    // Behavioural memory: combinational read, clocked write.
    assign mem_rdata = mem[mem_addr[9:0]];
    always @(posedge clk) if (mem_en && mem_we) begin
        mem[mem_addr[9:0]] <= mem_wdata;
        n_memwr <= n_memwr + 1;
    end

    function automatic logic [7:0] pat(input logic [15:0] a);
        return 8'(a[9:0] * 7 + 3);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // All tasks start and end just after a falling edge.
    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
        @(posedge clk); @(negedge clk);
        sfr_wr = 0;
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a; #(CLK_PERIOD/4); d = sfr_rdata;
    endtask

    task automatic ptr_read(input int ch, output logic [15:0] p);
        logic [7:0] h, l;
        sfr_read(ch == 1 ? A_P1H : A_P2H, h);
        sfr_read(ch == 1 ? A_P1L : A_P2L, l);
        p = {h, l};
    endtask

    task automatic ptr_load(input int ch, input logic [15:0] p);
        sfr_write(ch == 1 ? A_P1H : A_P2H, p[15:8]);
        sfr_write(ch == 1 ? A_P1L : A_P2L, p[7:0]);
    endtask

    task automatic xd_cycle(input logic we, input logic [15:0] a, input logic [7:0] d,
                            output logic [7:0] rd, output logic hit);
        xd_req = 1; xd_we = we; xd_addr = a; xd_wdata = d;
        #(CLK_PERIOD/4); rd = xd_rdata; hit = xd_hit;
        @(posedge clk); @(negedge clk);
        xd_req = 0; xd_we = 0;
    endtask

    task automatic t_reset;
        logic [7:0] v; logic [15:0] p;
        sfr_read(A_CTRL, v); chk("R11 ctrl", v, 0);
        ptr_read(1, p); chk("R11 ptr1", p, 0);
        ptr_read(2, p); chk("R11 ptr2", p, 0);
    endtask

    task automatic t_load_readback;
        logic [7:0] v; logic [15:0] p;
        ptr_load(1, 16'hA1B2); ptr_load(2, 16'h3C4D);
        ptr_read(1, p); chk("R1 ptr1", p, 16'hA1B2);
        ptr_read(2, p); chk("R1 ptr2", p, 16'h3C4D);
        sfr_write(A_CTRL, 8'hFF); sfr_read(A_CTRL, v); chk("R2 ctrl mask", v, 8'h07);
    endtask

    task automatic t_write_port;
        logic [7:0] rd; logic h; logic [15:0] p;
        sfr_write(A_CTRL, 8'h07); ptr_load(2, 16'h03C0);
        for (int i = 0; i < 4; i++) xd_cycle(1, PORT2, 8'h50 + 8'(i), rd, h);
        for (int i = 0; i < 4; i++) chk("R4 stored byte", mem[10'h3C0 + i], 8'h50 + 8'(i));
        ptr_read(2, p); chk("R5 ptr2 advanced", p, 16'h03C4);
    endtask

    task automatic t_read_port;
        logic [7:0] rd; logic h; logic [15:0] p;
        sfr_write(A_CTRL, 8'h07); ptr_load(1, 16'h0020);
        for (int i = 0; i < 3; i++) begin
            xd_cycle(0, PORT1, 0, rd, h);
            chk("R3 R5 consecutive read", rd, pat(16'h0020 + 16'(i)));
            chk("R3 hit", 16'(h), 1);
        end
        ptr_read(1, p); chk("R5 ptr1", p, 16'h0023);
    endtask

    task automatic t_wrap;
        logic [7:0] rd; logic h; logic [15:0] p;
        sfr_write(A_CTRL, 8'h03); ptr_load(1, 16'hFFFF);
        xd_cycle(0, PORT1, 0, rd, h); chk("R3 read at FFFF", rd, pat(16'hFFFF));
        ptr_read(1, p); chk("R7 wrap", p, 16'h0000);
        ptr_load(1, 16'h00FF); xd_cycle(0, PORT1, 0, rd, h);
        ptr_read(1, p); chk("R7 carry", p, 16'h0100);
    endtask

    task automatic t_copy;
        logic [7:0] rd; logic h; logic [15:0] p;
        sfr_write(A_CTRL, 8'h07); ptr_load(1, 16'h0100); ptr_load(2, 16'h0200);
        for (int i = 0; i < 6; i++) begin
            xd_cycle(0, PORT1, 0, rd, h); xd_cycle(1, PORT2, rd, rd, h);
        end
        for (int i = 0; i < 6; i++) chk("R12 copy order", mem[10'h200 + i], pat(16'h0100 + 16'(i)));
        ptr_read(1, p); chk("R12 src end", p, 16'h0106);
        ptr_read(2, p); chk("R12 dst end", p, 16'h0206);
        sfr_write(A_CTRL, 8'h03); ptr_load(1, 16'h0180); ptr_load(2, 16'h0300);
        for (int i = 0; i < 4; i++) begin
            xd_cycle(0, PORT1, 0, rd, h); xd_cycle(1, PORT2, rd, rd, h);
        end
        chk("R12 single dst last byte", mem[10'h300], pat(16'h0183));
        chk("R12 next untouched", mem[10'h301], pat(16'h0301));
        ptr_read(2, p); chk("R6 ptr2 held", p, 16'h0300);
        ptr_read(1, p); chk("R5 ptr1 stepped", p, 16'h0184);
    endtask

    task automatic t_disabled;
        logic [7:0] rd; logic h; logic [15:0] p; int w0;
        sfr_write(A_CTRL, 8'h06); ptr_load(1, 16'h0040); ptr_load(2, 16'h0250);
        w0 = n_memwr;
        xd_cycle(1, PORT2, 8'hEE, rd, h);
        xd_cycle(0, PORT1, 0, rd, h); chk("R8 read zero", rd, 0);
        chk("R8 no mem write", 16'(n_memwr - w0), 0);
        chk("R8 mem intact", mem[10'h250], pat(16'h0250));
        ptr_read(1, p); chk("R8 ptr1 held", p, 16'h0040);
        ptr_read(2, p); chk("R8 ptr2 held", p, 16'h0250);
    endtask

    task automatic t_non_port;
        logic [7:0] rd; logic h; logic [15:0] p; int w0;
        sfr_write(A_CTRL, 8'h07); ptr_load(1, 16'h0010); ptr_load(2, 16'h0011);
        w0 = n_memwr;
        xd_cycle(0, 16'hE67A, 0, rd, h); chk("R9 no hit low", 16'(h), 0);
        xd_cycle(1, 16'hE67D, 8'h99, rd, h); chk("R9 no hit high", 16'(h), 0);
        chk("R9 no mem write", 16'(n_memwr - w0), 0);
        ptr_read(1, p); chk("R9 ptr1 held", p, 16'h0010);
        ptr_read(2, p); chk("R9 ptr2 held", p, 16'h0011);
    endtask

    task automatic t_collision;
        logic [15:0] p;
        sfr_write(A_CTRL, 8'h07); ptr_load(1, 16'h1234);
        sfr_wr = 1; sfr_addr = A_P1L; sfr_wdata = 8'h55;
        xd_req = 1; xd_we = 0; xd_addr = PORT1;
        @(posedge clk); @(negedge clk);
        sfr_wr = 0; xd_req = 0;
        ptr_read(1, p); chk("R10 cpu write wins", p, 16'h1255);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = pat(16'(i));
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_load_readback();
        t_write_port();
        t_read_port();
        t_wrap();
        t_copy();
        t_disabled();
        t_non_port();
        t_collision();
        finish_run();
    end
endmodule